// File: doc/BRIEF.md
# Programmable-Logic Output Cell with Array Feedback

This block is one output cell of a sum-of-products programmable logic device. It takes the OR sum built by the array for this cell and a separate three-state control term. It drives an active-low pad through a three-state model and returns one feedback bit to the array. A parameter fixes the cell's mode when the device is configured.

In registered mode the sum is captured by a rising-edge flip-flop. The pad is enabled by a device-wide active-low enable. The register value goes back to the array internally, so a state machine keeps stepping while its pads are disabled. In combinational mode the pad shows the inverted sum while the control term is true. Feedback is then read from the pad, so the pin can serve as a bidirectional I/O, or as a plain input when the control term never goes true. A second parameter removes that pad feedback for cells that have none.

A power-on reset clears the register. A test preload port can force any state into it. When the supply-good flag is low, the pad is released in every mode.

Top module: `pal_out_cell`

## Requirements
- R1: In registered mode, `pin_oe` is 1 exactly when `supply_ok` is 1 and `oe_n` is 0, and `pin_o` is always the inverse of the register value.
- R2: In registered mode, with `pre_en` low, the register takes `sum_in` on each rising edge of `clk` and holds it between edges.
- R3: `por_n` low clears the register to 0 at once, without waiting for a clock edge, so an enabled registered pad reads 1 (`pin_o` = 1).
- R4: In registered mode, `fb` equals the register value whether or not the pad is enabled, so capture continues while `oe_n` is 1.
- R5: When `pre_en` is 1 at a rising clock edge, the register takes `pre_val` and `sum_in` is ignored.
- R6: In combinational mode, `pin_o` is the inverse of `sum_in` and `pin_oe` equals `tri_term` AND `supply_ok`; `oe_n` has no effect.
- R7: In combinational mode with feedback present, `fb` follows the pad level `pin_i`, both when the cell drives the pad and when an outside source drives it.
- R8: While `supply_ok` is 0, `pin_oe` is 0 in every mode.
- R9: With feedback removed (`HAS_FB` = 0) in combinational mode, `fb` is held at 0 whatever the pad level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock, rising edge active |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_ok | input | 1 | Supply-good flag; low releases the pad |
| oe_n | input | 1 | Shared enable for registered pads, active low |
| sum_in | input | 1 | OR sum from the array for this cell |
| tri_term | input | 1 | Three-state control product term (combinational mode) |
| pre_en | input | 1 | Test preload enable |
| pre_val | input | 1 | Test preload value |
| pin_i | input | 1 | Level sensed at the pad |
| pin_o | output | 1 | Value driven to the pad (active low) |
| pin_oe | output | 1 | Pad driver enable |
| fb | output | 1 | Feedback bit to the array |

## Verification
The bench builds three copies of the cell side by side. The first is a registered cell (`REGISTERED`=1). The second is a combinational cell with pad feedback (`REGISTERED`=0, `HAS_FB`=1). The third is a combinational cell without it (`REGISTERED`=0, `HAS_FB`=0). A pad model in the bench resolves each combinational pin between the cell's driver, an outside driver and a pull-up. With that model the bidirectional case and the dedicated-input case can both be reached, and so can the fixed-zero feedback of a cell without a return path. The registered copy covers capture, asynchronous clear, preload priority and sequencing behind a disabled pad.

// File: rtl/pal_out_cell.sv
module pal_out_cell #(
  parameter bit REGISTERED = 1'b1,
  parameter bit HAS_FB     = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic oe_n,
  input  logic sum_in,
  input  logic tri_term,
  input  logic pre_en,
  input  logic pre_val,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_oe,
  output logic fb
);

  logic q;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      q <= 1'b0;
    else if (pre_en) q <= pre_val;
    else             q <= sum_in;

  assign pin_o  = REGISTERED ? ~q : ~sum_in;
  assign pin_oe = supply_ok & (REGISTERED ? ~oe_n : tri_term);
  assign fb     = REGISTERED ? q : (HAS_FB ? pin_i : 1'b0);

  p_off_r8: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |-> !pin_oe);

  if (REGISTERED) begin : g_reg_chk
    p_capture_r2: assert property (@(posedge clk) disable iff (!por_n)
      !pre_en |=> fb == $past(sum_in));
    p_preload_r5: assert property (@(posedge clk) disable iff (!por_n)
      pre_en |=> fb == $past(pre_val));
    p_pin_inv_r1: assert property (@(posedge clk) disable iff (!por_n)
      pin_o != fb);
  end else begin : g_comb_chk
    p_tri_off_r6: assert property (@(posedge clk) disable iff (!por_n)
      !tri_term |-> !pin_oe);
  end

endmodule

// File: tb/test_pal_out_cell.sv
module test_pal_out_cell;
  logic clk = 1'b0;
  logic por_n, supply_ok, oe_n, sum_in, tri_term, pre_en, pre_val;
  logic ext_en, ext_v;
  logic r_o, r_oe, r_fb, c_o, c_oe, c_fb, n_o, n_oe, n_fb;
  logic pad_c, pad_n;
  int checks = 0, bad = 0;

  always #2.5 clk = ~clk;

  assign pad_c = c_oe ? c_o : (ext_en ? ext_v : 1'b1);
  assign pad_n = n_oe ? n_o : (ext_en ? ext_v : 1'b1);

  pal_out_cell #(.REGISTERED(1'b1), .HAS_FB(1'b1)) i_pal_out_cell (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .oe_n(oe_n),
    .sum_in(sum_in), .tri_term(tri_term), .pre_en(pre_en), .pre_val(pre_val),
    .pin_i(1'b1), .pin_o(r_o), .pin_oe(r_oe), .fb(r_fb));

  pal_out_cell #(.REGISTERED(1'b0), .HAS_FB(1'b1)) i_pal_out_cell_c (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .oe_n(oe_n),
    .sum_in(sum_in), .tri_term(tri_term), .pre_en(pre_en), .pre_val(pre_val),
    .pin_i(pad_c), .pin_o(c_o), .pin_oe(c_oe), .fb(c_fb));

  pal_out_cell #(.REGISTERED(1'b0), .HAS_FB(1'b0)) i_pal_out_cell_n (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .oe_n(oe_n),
    .sum_in(sum_in), .tri_term(tri_term), .pre_en(pre_en), .pre_val(pre_val),
    .pin_i(pad_n), .pin_o(n_o), .pin_oe(n_oe), .fb(n_fb));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    por_n = 0; supply_ok = 1; oe_n = 0; sum_in = 1; tri_term = 0;
    pre_en = 0; pre_val = 0; ext_en = 0; ext_v = 0;
    tick(); tick();
    chk("R3 reset fb", r_fb, 1'b0);
    chk("R3 reset pin high", r_o, 1'b1);
    chk("R1 enabled", r_oe, 1'b1);
    por_n = 1;
  endtask

  task automatic t_capture();
    sum_in = 1; tick();
    chk("R2 capture 1", r_fb, 1'b1);
    chk("R1 pin inverse", r_o, 1'b0);
    #1 sum_in = 0; #1;
    chk("R2 hold between edges", r_fb, 1'b1);
    tick();
    chk("R2 capture 0", r_fb, 1'b0);
  endtask

  task automatic t_hidden_seq();
    oe_n = 1; #1;
    chk("R1 oe_n high disables", r_oe, 1'b0);
    sum_in = 1; tick();
    chk("R4 sequencing while disabled", r_fb, 1'b1);
    sum_in = 0; tick();
    chk("R4 sequencing while disabled 2", r_fb, 1'b0);
    oe_n = 0; #1;
    chk("R1 re-enable", r_oe, 1'b1);
  endtask

  task automatic t_preload();
    pre_en = 1; pre_val = 1; sum_in = 0; tick();
    chk("R5 preload 1 over sum", r_fb, 1'b1);
    pre_val = 0; sum_in = 1; tick();
    chk("R5 preload 0 over sum", r_fb, 1'b0);
    pre_en = 0; tick();
    chk("R2 capture after preload", r_fb, 1'b1);
  endtask

  task automatic t_async_clear();
    #1 por_n = 0; #0.5;
    chk("R3 async clear", r_fb, 1'b0);
    chk("R3 async clear pin", r_o, 1'b1);
    tick(); por_n = 1;
  endtask

  task automatic t_comb();
    tri_term = 1; sum_in = 1; oe_n = 1; #1;
    chk("R6 comb enable", c_oe, 1'b1);
    chk("R6 comb pin inverse", c_o, 1'b0);
    chk("R7 fb from driven pad", c_fb, 1'b0);
    sum_in = 0; oe_n = 0; #1;
    chk("R6 comb pin inverse 2", c_o, 1'b1);
    chk("R7 fb from driven pad 2", c_fb, 1'b1);
    tri_term = 0; #1;
    chk("R6 tri_term low disables", c_oe, 1'b0);
  endtask

  task automatic t_input_use();
    tri_term = 0; sum_in = 1; ext_en = 1; ext_v = 0; #1;
    chk("R7 pad as input 0", c_fb, 1'b0);
    ext_v = 1; #1;
    chk("R7 pad as input 1", c_fb, 1'b1);
    chk("R9 no feedback", n_fb, 1'b0);
    tri_term = 1; ext_en = 0; sum_in = 0; #1;
    chk("R9 no feedback driven", n_fb, 1'b0);
  endtask

  task automatic t_supply();
    tri_term = 1; oe_n = 0; #1;
    supply_ok = 0; #1;
    chk("R8 registered off", r_oe, 1'b0);
    chk("R8 comb off", c_oe, 1'b0);
    chk("R8 comb nofb off", n_oe, 1'b0);
    supply_ok = 1; #1;
    chk("R8 restore", c_oe, 1'b1);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_hidden_seq();
    t_preload();
    t_async_clear();
    t_comb();
    t_input_use();
    t_supply();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #100000;
    checks++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule